// File: doc/BRIEF.md
# Bus-Controller Message Sequencer

This block is the protocol engine of a bus controller on a dual-redundant command/response serial bus. A rising start request makes it capture one or two host-supplied command words and decode them into a message shape. It then drives the command word or words, followed by any outgoing data words, through a word-level transmit handshake toward a Manchester encoder. Depending on the shape, it next waits for a terminal status reply and collects reply data words into a receive FIFO.

Every message closes with exactly one outcome pulse: valid-message or error. Outgoing data may be preloaded or written on the fly. The encoder's ready strobe marks the last moment by which the next data word must be available. The no-response watchdog has two gap lengths and stays correct at either supported clock rate.

Command word layout used throughout: bits 15:11 terminal address (31 = broadcast), bit 10 direction (1 = terminal transmits), bits 9:5 subaddress, bits 4:0 word count or mode code.

Top module: `bc_msg_sequencer`

## Requirements
- R1: A message starts only on a 0-to-1 transition of `start_pin | start_bit` seen while idle. A held-high request, a rise while the other source is already high, or a rise during a message does not start one. Each accepted start pulses `rxf_clear` for one cycle.
- R2: With exactly one of `bus_en_a`/`bus_en_b` set, that bus carries the message (`tx_bus_b` = 1 for B). Three cases end the start with `msg_error` and send no word at all: both enables set, neither set, or the chosen bus's inhibit input high.
- R3: For a non-broadcast receive command (bit 10 = 0, subaddress not 0 or 31), the sequencer sends the command word (`tx_is_cmd` = 1). It then sends N data words (`tx_is_cmd` = 0) in FIFO load order, waits for a status word (`rx_is_cmd` = 1), and pulses `msg_valid`.
- R4: A count field of 0 means 32 data words.
- R5: For a transmit command, the status word is followed by N data words (`rx_is_cmd` = 0). Each is pushed to the receive FIFO in arrival order. The last status word received stays on `status_word`. A word with the wrong sync type in either phase ends the message with `msg_error`.
- R6: With `rt_to_rt` set, the sequencer sends `cmd_word1` (receive command) and then `cmd_word2` (transmit command). It then accepts the transmitter's status word and N data words, with N taken from `cmd_word2`.
- R7: With address 31 in `cmd_word1`, `msg_valid` follows the last transmitted word directly, with no status wait.
- R8: Subaddress 0 or 31 marks a mode code. Exactly one data word is attached for codes 16–31 and none for 0–15. Its direction follows bit 10.
- R9: While awaiting a reply word, silence for `gap_us × MHz` cycles raises `msg_error`. `gap_us` is 17 (`long_gap`=0) or 131 (`long_gap`=1), and MHz is 24 (`clk_half`=0) or 12 (`clk_half`=1). Each received word restarts the count.
- R10: During the outgoing data phase, a `tx_ready` strobe with `txf_empty` high aborts the message with `msg_error` instead of `msg_valid`. Data written before each deadline, even during the message, is sent normally.
- R11: After reset the block is idle with no outcome pulse. Each started message ends with exactly one one-cycle pulse, either `msg_valid` or `msg_error`, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (24 or 12 MHz in the target system) |
| rst_n | input | 1 | Active-low synchronous reset |
| start_pin | input | 1 | Hardware start request |
| start_bit | input | 1 | Register start request, ORed with the pin |
| long_gap | input | 1 | 0: 17 µs reply gap, 1: 131 µs |
| clk_half | input | 1 | 1: clock runs at half rate (12 MHz) |
| bus_en_a | input | 1 | Transmit enable, bus A |
| bus_en_b | input | 1 | Transmit enable, bus B |
| tx_inhibit_a | input | 1 | Transmit inhibit override, bus A |
| tx_inhibit_b | input | 1 | Transmit inhibit override, bus B |
| rt_to_rt | input | 1 | Use both command words as a terminal-to-terminal transfer |
| cmd_word1 | input | 16 | First command word |
| cmd_word2 | input | 16 | Second (transmit) command word |
| tx_valid | output | 1 | Word offered to encoder |
| tx_ready | input | 1 | Encoder takes word / next-word deadline strobe |
| tx_word | output | 16 | Outgoing word |
| tx_is_cmd | output | 1 | Outgoing word uses command sync |
| tx_bus_b | output | 1 | Outgoing word goes to bus B |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_data | input | 16 | Transmit FIFO head word |
| txf_pop | output | 1 | Transmit FIFO read strobe |
| rx_valid | input | 1 | Decoder delivers a word |
| rx_word | input | 16 | Received word |
| rx_is_cmd | input | 1 | Received word had command/status sync |
| rxf_push | output | 1 | Receive FIFO write strobe |
| rxf_data | output | 16 | Receive FIFO write word |
| rxf_clear | output | 1 | Receive FIFO flush on accepted start |
| status_word | output | 16 | Last status word accepted |
| busy | output | 1 | Message in progress |
| msg_valid | output | 1 | Message completed correctly (pulse) |
| msg_error | output | 1 | Message aborted (pulse) |

## Verification
The bench aims at the count field boundary. A zero count must give a full 32-word burst; a design that read it as zero words would end after the command. Mode code 2 with an empty FIFO must send no data word, or the deadline abort fires. For broadcast, a design that waited for status would time out instead of pulsing valid. For terminal-to-terminal transfers, sending the commands in the wrong order or taking the count from the first word shows up in the scoreboard's expected word stream. The reply gap is timed to the cycle at 24 MHz short gap and at 12 MHz long gap, so a missing clock scaling is off by a factor of two. The bench also covers a held start level, a start during a running message, both bus enables set, an inhibited bus, and a starved transmit FIFO, each of which would otherwise emit stray words or a wrong outcome.

// File: rtl/bcseq_pkg.sv
package bcseq_pkg;

  localparam int WORD_W = 16;
  localparam int CNT_W  = 6;
  localparam logic [4:0] BCAST_ADDR = 5'd31;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD1, S_CMD2, S_TXD, S_STAT, S_RXD
  } seq_state_t;

  typedef struct packed {
    logic             two_cmd;
    logic             want_stat;
    logic [CNT_W-1:0] tx_n;
    logic [CNT_W-1:0] rx_n;
  } msg_plan_t;

  // count field: zero encodes the maximum burst of 32
  function automatic logic [CNT_W-1:0] word_count(logic [4:0] f);
    return (f == 5'd0) ? 6'd32 : {1'b0, f};
  endfunction

  function automatic logic is_mode(word_t cw);
    return (cw[9:5] == 5'd0) || (cw[9:5] == 5'd31);
  endfunction

  // data words carried by one command, mode codes 16..31 carry one
  function automatic logic [CNT_W-1:0] payload(word_t cw);
    if (is_mode(cw)) return cw[4] ? 6'd1 : 6'd0;
    return word_count(cw[4:0]);
  endfunction

  function automatic msg_plan_t plan_msg(word_t cw1, word_t cw2, logic rt2rt);
    msg_plan_t p;
    logic bc;
    p  = '0;
    bc = (cw1[15:11] == BCAST_ADDR);
    if (rt2rt) begin
      p.two_cmd   = 1'b1;
      p.want_stat = 1'b1;
      p.rx_n      = word_count(cw2[4:0]);
    end else if (cw1[10]) begin
      if (!bc) begin
        p.want_stat = 1'b1;
        p.rx_n      = payload(cw1);
      end
    end else begin
      p.tx_n      = payload(cw1);
      p.want_stat = !bc;
    end
    return p;
  endfunction

  function automatic int unsigned gap_cycles(int unsigned us, int unsigned mhz, logic half);
    return half ? (us * mhz) / 2 : us * mhz;
  endfunction

endpackage

// File: rtl/bcseq_start_detect.sv
module bcseq_start_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic start_pin,
  input  logic start_bit,
  input  logic armed,
  output logic trigger
);
  logic req, req_q;

  assign req = start_pin | start_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req;
  end

  assign trigger = armed & req & ~req_q;
endmodule

// File: rtl/bcseq_bus_sel.sv
module bcseq_bus_sel (
  input  logic en_a,
  input  logic en_b,
  input  logic inh_a,
  input  logic inh_b,
  output logic bus_b,
  output logic bus_ok
);
  assign bus_b  = en_b & ~en_a;
  assign bus_ok = (en_a ^ en_b) & ~(en_a ? inh_a : inh_b);
endmodule

// File: rtl/bcseq_gap_timer.sv
module bcseq_gap_timer
  import bcseq_pkg::*;
#(
  parameter int CLK_MHZ  = 24,
  parameter int SHORT_US = 17,
  parameter int LONG_US  = 131,
  parameter int TMR_W    = $clog2(LONG_US * CLK_MHZ + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic long_gap,
  input  logic clk_half,
  output logic expired
);
  logic [TMR_W-1:0] count, limit;

  always_comb begin
    if (long_gap) limit = TMR_W'(gap_cycles(LONG_US, CLK_MHZ, clk_half));
    else          limit = TMR_W'(gap_cycles(SHORT_US, CLK_MHZ, clk_half));
  end

  assign expired = run && (count >= limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)                count <= '0;
    else if (!run || restart)  count <= '0;
    else if (!expired)         count <= count + 1'b1;
  end
endmodule

// File: rtl/bc_msg_sequencer.sv
module bc_msg_sequencer
  import bcseq_pkg::*;
#(
  parameter int CLK_MHZ  = 24,
  parameter int SHORT_US = 17,
  parameter int LONG_US  = 131,
  parameter int TMR_W    = $clog2(LONG_US * CLK_MHZ + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_pin,
  input  logic        start_bit,
  input  logic        long_gap,
  input  logic        clk_half,
  input  logic        bus_en_a,
  input  logic        bus_en_b,
  input  logic        tx_inhibit_a,
  input  logic        tx_inhibit_b,
  input  logic        rt_to_rt,
  input  logic [15:0] cmd_word1,
  input  logic [15:0] cmd_word2,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [15:0] tx_word,
  output logic        tx_is_cmd,
  output logic        tx_bus_b,
  input  logic        txf_empty,
  input  logic [15:0] txf_data,
  output logic        txf_pop,
  input  logic        rx_valid,
  input  logic [15:0] rx_word,
  input  logic        rx_is_cmd,
  output logic        rxf_push,
  output logic [15:0] rxf_data,
  output logic        rxf_clear,
  output logic [15:0] status_word,
  output logic        busy,
  output logic        msg_valid,
  output logic        msg_error
);

  // named internal events
  logic trigger, bus_b, bus_ok;
  logic tmr_run, tmr_expired;
  logic accept, deadline_miss, stat_ok, rx_data_ok, bad_sync;
  logic tx_last, rx_last;

  seq_state_t       state, post_tx;
  logic             post_tx_done;
  word_t            cw1_q, cw2_q, status_q;
  msg_plan_t        plan_q;
  logic [CNT_W-1:0] word_cnt;
  logic             bus_b_q;

  assign busy = (state != S_IDLE);

  bcseq_start_detect u_start (
    .clk(clk), .rst_n(rst_n), .start_pin(start_pin), .start_bit(start_bit),
    .armed(!busy), .trigger(trigger)
  );

  bcseq_bus_sel u_bus (
    .en_a(bus_en_a), .en_b(bus_en_b), .inh_a(tx_inhibit_a), .inh_b(tx_inhibit_b),
    .bus_b(bus_b), .bus_ok(bus_ok)
  );

  assign tmr_run = (state == S_STAT) || (state == S_RXD);

  bcseq_gap_timer #(
    .CLK_MHZ(CLK_MHZ), .SHORT_US(SHORT_US), .LONG_US(LONG_US), .TMR_W(TMR_W)
  ) u_gap (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .restart(rx_valid),
    .long_gap(long_gap), .clk_half(clk_half), .expired(tmr_expired)
  );

  // transmit side
  always_comb begin
    tx_valid = 1'b0;
    tx_word  = cw1_q;
    case (state)
      S_CMD1: begin tx_valid = 1'b1;        tx_word = cw1_q;    end
      S_CMD2: begin tx_valid = 1'b1;        tx_word = cw2_q;    end
      S_TXD:  begin tx_valid = !txf_empty;  tx_word = txf_data; end
      default: ;
    endcase
  end

  assign tx_is_cmd     = (state != S_TXD);
  assign tx_bus_b      = bus_b_q;
  assign accept        = tx_valid && tx_ready;
  assign deadline_miss = (state == S_TXD) && tx_ready && txf_empty;
  assign txf_pop       = (state == S_TXD) && tx_ready && !txf_empty;
  assign tx_last       = (word_cnt + 1'b1) == plan_q.tx_n;

  // receive side
  assign stat_ok    = (state == S_STAT) && rx_valid && rx_is_cmd;
  assign rx_data_ok = (state == S_RXD) && rx_valid && !rx_is_cmd;
  assign bad_sync   = rx_valid && (((state == S_STAT) && !rx_is_cmd) ||
                                   ((state == S_RXD) && rx_is_cmd));
  assign rx_last    = (word_cnt + 1'b1) == plan_q.rx_n;
  assign rxf_push   = rx_data_ok;
  assign rxf_data   = rx_word;
  assign rxf_clear  = trigger;
  assign status_word = status_q;

  // where the message goes once the last outgoing word is taken
  assign post_tx      = plan_q.want_stat ? S_STAT : S_IDLE;
  assign post_tx_done = !plan_q.want_stat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cw1_q     <= '0;
      cw2_q     <= '0;
      plan_q    <= '0;
      word_cnt  <= '0;
      bus_b_q   <= 1'b0;
      status_q  <= '0;
      msg_valid <= 1'b0;
      msg_error <= 1'b0;
    end else begin
      msg_valid <= 1'b0;
      msg_error <= 1'b0;
      case (state)
        S_IDLE: if (trigger) begin
          cw1_q    <= cmd_word1;
          cw2_q    <= cmd_word2;
          plan_q   <= plan_msg(cmd_word1, cmd_word2, rt_to_rt);
          bus_b_q  <= bus_b;
          word_cnt <= '0;
          if (bus_ok) state <= S_CMD1;
          else        msg_error <= 1'b1;
        end
        S_CMD1: if (accept) begin
          if (plan_q.two_cmd)           state <= S_CMD2;
          else if (plan_q.tx_n != '0)   state <= S_TXD;
          else begin
            state     <= post_tx;
            msg_valid <= post_tx_done;
          end
        end
        S_CMD2: if (accept) begin
          state     <= post_tx;
          msg_valid <= post_tx_done;
        end
        S_TXD: begin
          if (deadline_miss) begin
            state     <= S_IDLE;
            msg_error <= 1'b1;
          end else if (accept) begin
            word_cnt <= word_cnt + 1'b1;
            if (tx_last) begin
              state     <= post_tx;
              msg_valid <= post_tx_done;
            end
          end
        end
        S_STAT: begin
          if (stat_ok) begin
            status_q <= rx_word;
            word_cnt <= '0;
            if (plan_q.rx_n != '0) state <= S_RXD;
            else begin
              state     <= S_IDLE;
              msg_valid <= 1'b1;
            end
          end else if (bad_sync || tmr_expired) begin
            state     <= S_IDLE;
            msg_error <= 1'b1;
          end
        end
        S_RXD: begin
          if (rx_data_ok) begin
            word_cnt <= word_cnt + 1'b1;
            if (rx_last) begin
              state     <= S_IDLE;
              msg_valid <= 1'b1;
            end
          end else if (bad_sync || tmr_expired) begin
            state     <= S_IDLE;
            msg_error <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bcseq_checks.sv
module bcseq_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       msg_valid,
  input logic       msg_error,
  input logic       tx_valid,
  input logic       txf_pop,
  input logic       txf_empty,
  input logic       rxf_clear,
  input logic       bus_ok,
  input logic       tmr_expired,
  input logic       rx_valid,
  input logic [5:0] word_cnt
);

  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_valid && msg_error));

  a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> !msg_valid);

  a_r1_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_clear |-> !busy);

  a_r2_no_bus_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rxf_clear && !bus_ok) |=> (msg_error && !tx_valid));

  a_r10_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    txf_pop |-> !txf_empty);

  a_r9_silence_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_expired && !rx_valid) |=> msg_error);

  a_r4_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
    word_cnt <= 6'd32);

endmodule

bind bc_msg_sequencer bcseq_checks u_checks (
  .clk(clk), .rst_n(rst_n), .busy(busy), .msg_valid(msg_valid),
  .msg_error(msg_error), .tx_valid(tx_valid), .txf_pop(txf_pop),
  .txf_empty(txf_empty), .rxf_clear(rxf_clear), .bus_ok(bus_ok),
  .tmr_expired(tmr_expired), .rx_valid(rx_valid), .word_cnt(word_cnt)
);

// File: tb/bc_msg_sequencer_test.sv
`timescale 1ns/1ps
module bc_msg_sequencer_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        start_pin = 0, start_bit = 0, long_gap = 0, clk_half = 0;
  logic        bus_en_a = 1, bus_en_b = 0, tx_inhibit_a = 0, tx_inhibit_b = 0;
  logic        rt_to_rt = 0;
  logic [15:0] cmd_word1 = 0, cmd_word2 = 0;
  logic        tx_valid, tx_is_cmd, tx_bus_b, txf_pop;
  logic        tx_ready;
  logic [15:0] tx_word;
  logic        txf_empty = 1;
  logic [15:0] txf_data = 0;
  logic        rx_valid = 0, rx_is_cmd = 0;
  logic [15:0] rx_word = 0;
  logic        rxf_push, rxf_clear, busy, msg_valid, msg_error;
  logic [15:0] rxf_data, status_word;

  bc_msg_sequencer uut (.*);

  // scoreboard state
  int vec = 0, miss = 0, cyc = 0;
  int n_valid = 0, n_err = 0, n_clear = 0, last_acc = 0, err_cyc = 0;
  int base_v, base_e, base_c;
  bit pop_pend = 0, load_pend = 0, done = 0;
  logic [16:0] exp_tx[$];
  logic [15:0] exp_rx[$];
  logic [15:0] txq[$];
  logic [15:0] pend_q[$];
  logic        exp_bus_b = 0;
  string       cur_req = "R3";

  // encoder model: always ready, or one strobe every four cycles
  bit       enc_slow = 0;
  int       enc_phase = 0;
  assign tx_ready = enc_slow ? (enc_phase == 0) : 1'b1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sync_fifo();
    txf_empty = (txq.size() == 0);
    txf_data  = (txq.size() == 0) ? 16'h0 : txq[0];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  endtask

  // monitor: samples away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        logic [16:0] e;
        last_acc = cyc;
        if (exp_tx.size() == 0) check(0, cur_req, "unexpected tx word", {15'd0, tx_is_cmd, tx_word}, 0);
        else begin
          e = exp_tx.pop_front();
          check({tx_is_cmd, tx_word} == e, cur_req, "tx word", {15'd0, tx_is_cmd, tx_word}, {15'd0, e});
          check(tx_bus_b == exp_bus_b, "R2", "tx bus", tx_bus_b, exp_bus_b);
        end
        if (pend_q.size() > 0) load_pend = 1;
      end
      if (txf_pop) pop_pend = 1;
      if (rxf_push) begin
        if (exp_rx.size() == 0) check(0, "R5", "unexpected rx push", rxf_data, 0);
        else begin
          logic [15:0] r;
          r = exp_rx.pop_front();
          check(rxf_data == r, "R5", "rx fifo word", rxf_data, r);
        end
      end
      if (msg_valid) n_valid++;
      if (msg_error) begin n_err++; err_cyc = cyc; end
      if (rxf_clear) n_clear++;
    end
  end

  // FIFO and encoder updates just after the edge
  always @(posedge clk) begin
    #1;
    enc_phase = (enc_phase + 1) % 4;
    if (pop_pend)  begin void'(txq.pop_front()); pop_pend = 0; end
    if (load_pend) begin txq.push_back(pend_q.pop_front()); load_pend = 0; end
    sync_fifo();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R11", "watchdog expired", cyc, 0);
    finish_run();
  end

  function automatic logic [15:0] cw(int addr, int tr, int sa, int cnt);
    return {addr[4:0], tr[0], sa[4:0], cnt[4:0]};
  endfunction

  task automatic load(logic [15:0] w);
    txq.push_back(w); sync_fifo();
  endtask

  task automatic want_tx(logic [15:0] w, logic is_cmd);
    exp_tx.push_back({is_cmd, w});
  endtask

  task automatic mark();
    base_v = n_valid; base_e = n_err; base_c = n_clear;
  endtask

  task automatic fire();
    mark();
    @(posedge clk); #2 start_bit = 1;
    @(posedge clk); #2 start_bit = 0;
  endtask

  task automatic send_rx(logic [15:0] w, logic is_cmd);
    @(posedge clk); #2 rx_valid = 1; rx_word = w; rx_is_cmd = is_cmd;
    @(posedge clk); #2 rx_valid = 0;
  endtask

  task automatic drained();
    for (int i = 0; i < 3000 && exp_tx.size() != 0; i++) @(negedge clk);
  endtask

  task automatic respond(logic [15:0] st);
    drained();
    repeat (3) @(posedge clk);
    send_rx(st, 1'b1);
  endtask

  task automatic outcome(string req, bit want_valid);
    for (int i = 0; i < 5000 && n_valid == base_v && n_err == base_e; i++) @(negedge clk);
    @(negedge clk);
    check((n_valid - base_v) == int'(want_valid), req, "valid count", n_valid - base_v, int'(want_valid));
    check((n_err - base_e) == int'(!want_valid), req, "error count", n_err - base_e, int'(!want_valid));
    check(exp_tx.size() == 0, req, "tx words left", exp_tx.size(), 0);
    check(exp_rx.size() == 0, req, "rx words left", exp_rx.size(), 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R11: reset state
    check(busy == 0 && msg_valid == 0 && msg_error == 0, "R11", "idle after reset", busy, 0);
    check(tx_valid == 0, "R11", "no word after reset", tx_valid, 0);

    // R3: BC to RT, three words, start clears receive FIFO (R1)
    cur_req = "R3";
    cmd_word1 = cw(5, 0, 2, 3);
    want_tx(cmd_word1, 1);
    for (int i = 0; i < 3; i++) begin load(16'hA100 + 16'(i)); want_tx(16'hA100 + 16'(i), 0); end
    fire();
    respond(16'h2800);
    outcome("R3", 1);
    check(n_clear - base_c == 1, "R1", "rx fifo clear pulses", n_clear - base_c, 1);
    check(status_word == 16'h2800, "R5", "status word kept", status_word, 16'h2800);

    // R5: RT to BC, two words
    cur_req = "R5";
    cmd_word1 = cw(6, 1, 4, 2);
    want_tx(cmd_word1, 1);
    exp_rx.push_back(16'hB001); exp_rx.push_back(16'hB002);
    fire();
    respond(16'h3000);
    send_rx(16'hB001, 0); send_rx(16'hB002, 0);
    outcome("R5", 1);
    check(status_word == 16'h3000, "R5", "status word", status_word, 16'h3000);

    // R5: data sync where status expected
    cmd_word1 = cw(6, 1, 4, 1);
    want_tx(cmd_word1, 1);
    fire();
    drained(); repeat (2) @(posedge clk);
    send_rx(16'h1111, 0);
    outcome("R5", 0);

    // R4: count field 0 means 32 words
    cur_req = "R4";
    cmd_word1 = cw(9, 0, 3, 0);
    want_tx(cmd_word1, 1);
    for (int i = 0; i < 32; i++) begin load(16'h0400 + 16'(i * 3)); want_tx(16'h0400 + 16'(i * 3), 0); end
    fire();
    respond(16'h4800);
    outcome("R4", 1);

    // R6: RT to RT, receive command first, count from transmit command
    cur_req = "R6";
    rt_to_rt = 1;
    cmd_word1 = cw(3, 0, 1, 5);
    cmd_word2 = cw(7, 1, 1, 2);
    want_tx(cmd_word1, 1); want_tx(cmd_word2, 1);
    exp_rx.push_back(16'hC001); exp_rx.push_back(16'hC002);
    fire();
    respond(16'h3800);
    send_rx(16'hC001, 0); send_rx(16'hC002, 0);
    outcome("R6", 1);
    rt_to_rt = 0;

    // R7: broadcast receive, no status wait
    cur_req = "R7";
    cmd_word1 = cw(31, 0, 5, 3);
    want_tx(cmd_word1, 1);
    for (int i = 0; i < 3; i++) begin load(16'hD000 + 16'(i)); want_tx(16'hD000 + 16'(i), 0); end
    fire();
    outcome("R7", 1);

    // R8: broadcast mode code 17 with one data word
    cur_req = "R8";
    cmd_word1 = cw(31, 0, 0, 17);
    want_tx(cmd_word1, 1); load(16'hE017); want_tx(16'hE017, 0);
    fire();
    outcome("R8", 1);
    // R8: transmit mode code 18 to one terminal, one reply data word
    cmd_word1 = cw(4, 1, 31, 18);
    want_tx(cmd_word1, 1);
    exp_rx.push_back(16'hE018);
    fire();
    respond(16'h2000);
    send_rx(16'hE018, 0);
    outcome("R8", 1);
    // R8: mode code 2 carries no data word (FIFO empty)
    cmd_word1 = cw(4, 0, 0, 2);
    want_tx(cmd_word1, 1);
    fire();
    respond(16'h2000);
    outcome("R8", 1);

    // R9: short gap at full clock rate
    cur_req = "R9";
    cmd_word1 = cw(8, 0, 1, 1);
    want_tx(cmd_word1, 1); load(16'hF001); want_tx(16'hF001, 0);
    fire();
    drained();
    outcome("R9", 0);
    check(err_cyc - last_acc >= 408 && err_cyc - last_acc <= 410, "R9", "short gap cycles", err_cyc - last_acc, 409);

    // R9: long gap at half clock, start during message ignored (R1)
    long_gap = 1; clk_half = 1;
    want_tx(cmd_word1, 1); load(16'hF002); want_tx(16'hF002, 0);
    fire();
    drained();
    repeat (100) @(posedge clk);
    #2 start_pin = 1; @(posedge clk); #2 start_pin = 0;
    outcome("R9", 0);
    check(err_cyc - last_acc >= 1572 && err_cyc - last_acc <= 1574, "R9", "long gap half clock cycles", err_cyc - last_acc, 1573);
    check(n_clear - base_c == 1, "R1", "start while busy ignored", n_clear - base_c, 1);
    long_gap = 0; clk_half = 0;

    // R10: FIFO runs dry at a deadline
    cur_req = "R10";
    cmd_word1 = cw(10, 0, 2, 2);
    want_tx(cmd_word1, 1); load(16'h5A01); want_tx(16'h5A01, 0);
    fire();
    outcome("R10", 0);

    // R10: data written on the fly before each deadline
    enc_slow = 1;
    cmd_word1 = cw(12, 0, 6, 3);
    want_tx(cmd_word1, 1);
    for (int i = 0; i < 3; i++) begin pend_q.push_back(16'h6600 + 16'(i)); want_tx(16'h6600 + 16'(i), 0); end
    fire();
    respond(16'h6000);
    outcome("R10", 1);
    enc_slow = 0;

    // R2: bus B selected
    cur_req = "R2";
    bus_en_a = 0; bus_en_b = 1; exp_bus_b = 1;
    cmd_word1 = cw(2, 0, 1, 1);
    want_tx(cmd_word1, 1); load(16'h7001); want_tx(16'h7001, 0);
    fire();
    respond(16'h1000);
    outcome("R2", 1);
    // R2: both enables set, nothing leaves and FIFO untouched
    bus_en_a = 1; exp_bus_b = 0;
    load(16'h7002);
    fire();
    outcome("R2", 0);
    check(txq.size() == 1, "R2", "fifo untouched", txq.size(), 1);
    // R2: chosen bus inhibited
    bus_en_b = 0; tx_inhibit_a = 1;
    fire();
    outcome("R2", 0);
    check(txq.size() == 1, "R2", "fifo untouched inhibit", txq.size(), 1);
    tx_inhibit_a = 0;
    txq.delete(); sync_fifo();

    // R1: held level and rise under a held pin start only once
    cur_req = "R1";
    cmd_word1 = cw(31, 1, 0, 1);
    want_tx(cmd_word1, 1);
    mark();
    @(posedge clk); #2 start_pin = 1;
    outcome("R1", 1);
    repeat (20) @(posedge clk);
    #2 start_bit = 1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(n_clear - base_c == 1, "R1", "held request starts once", n_clear - base_c, 1);
    check(busy == 0, "R1", "no restart while held", busy, 0);
    #1 start_pin = 0; start_bit = 0;

    repeat (5) @(posedge clk);
    finish_run();
  end

endmodule